// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces the frequency tuning word for a DDS phase accumulator. With sweeping turned off, the word follows the currently active profile word, one register late. With sweeping turned on, the word becomes a linear ramp between two endpoint words. The low endpoint is `lo_ftw` and the high endpoint is `hi_ftw`, and the block expects `lo_ftw <= hi_ftw`. Each direction has its own step size and its own step interval. The final step toward an endpoint is clamped, so the word lands exactly on that endpoint.

A sweep starts or changes direction on a one-cycle command strobe. In ordinary mode the word parks at the endpoint it reaches. In no-dwell mode, reaching the target makes the word jump straight back to the opposite endpoint, and the ramp then waits for the next command. There is an option that lets an update strobe restart the running step countdown. This allows the step timing to be realigned to a register load.

Top module: `fsweep_ramp`

## Requirements
- R1: While `sweep_en` is low, `ftw` equals the `act_ftw` value sampled at the previous clock edge, and `cmd_up` / `cmd_dn` are ignored.
- R2: A `cmd_up` strobe while sweeping starts a rising ramp toward `hi_ftw`. The word does not change on the command edge. The first step of `up_delta` lands `up_rate`+1 edges after the command edge, and each later step follows `up_rate`+1 edges after the one before.
- R3: A `cmd_dn` strobe works the same way as R2, but falls toward `lo_ftw` using `dn_delta` and `dn_rate`.
- R4: When the remaining distance to the target is no larger than the step, the step lands exactly on the target endpoint. The word never moves past that endpoint.
- R5: With `no_dwell` low, the word holds at the reached endpoint until a new command arrives.
- R6: With `no_dwell` high, the step that reaches the target sets the word to the opposite endpoint. The word then holds until a new command arrives.
- R7: A command in the opposite direction in the middle of a ramp continues from the current word. The countdown is loaded with the new direction's rate and the new direction's delta is used.
- R8: During a ramp, an `io_update` strobe with `rate_reload` high reloads the countdown, so the next step comes `rate`+1 edges after the strobe edge. With `rate_reload` low, `io_update` has no effect.
- R9: When `cmd_up` and `cmd_dn` arrive in the same cycle, `cmd_up` wins.
- R10: After reset, `ftw` is zero and no ramp is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Sweep enable; when low, the word follows the active profile |
| no_dwell | input | 1 | Return to the opposite endpoint on reaching the target |
| rate_reload | input | 1 | Allow `io_update` to reload the countdown |
| io_update | input | 1 | Update strobe |
| cmd_up | input | 1 | Strobe: ramp toward `hi_ftw` |
| cmd_dn | input | 1 | Strobe: ramp toward `lo_ftw` |
| act_ftw | input | FTW_W | Active profile word |
| lo_ftw | input | FTW_W | Low endpoint word |
| hi_ftw | input | FTW_W | High endpoint word |
| up_delta | input | FTW_W | Rising step size |
| dn_delta | input | FTW_W | Falling step size |
| up_rate | input | RATE_W | Rising interval minus one, in cycles |
| dn_rate | input | RATE_W | Falling interval minus one, in cycles |
| ftw | output | FTW_W | Current tuning word |

## Verification
A wrong countdown value shows up as a step that lands early or late. The error appears on `ftw` at the first step after the bad load, which is at most `rate`+1 cycles later. A wrong mode or a wrong clamp decision shows up on the step that reaches an endpoint: the word overshoots, stops short, or snaps to the wrong side. Every cycle of `ftw` is compared against a bench model, so these faults are reported on the very edge where they first become visible.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;

    typedef enum logic [1:0] {
        SM_HOLD = 2'd0,
        SM_UP   = 2'd1,
        SM_DN   = 2'd2
    } sweep_mode_e;

endpackage

// File: rtl/fsweep_rate_timer.sv
module fsweep_rate_timer #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [RATE_W-1:0] rate,
    output logic              expire
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (start) begin
            s_d.cnt = rate;
        end else if (active) begin
            if (s_q.cnt == '0) begin
                expire  = 1'b1;
                s_d.cnt = rate;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fsweep_stepper.sv
module fsweep_stepper #(
    parameter int FTW_W  = 32,
    parameter bit RISING = 1'b1
) (
    input  logic [FTW_W-1:0] cur,
    input  logic [FTW_W-1:0] delta,
    input  logic [FTW_W-1:0] tgt,
    input  logic [FTW_W-1:0] opp,
    input  logic             no_dwell,
    output logic [FTW_W-1:0] nxt,
    output logic             hit
);

    logic [FTW_W-1:0] gap;

    generate
        if (RISING) begin : g_rise
            always_comb begin
                gap = tgt - cur;
                hit = (cur >= tgt) || (gap <= delta);
                if (hit) nxt = no_dwell ? opp : tgt;
                else     nxt = cur + delta;
            end
        end else begin : g_fall
            always_comb begin
                gap = cur - tgt;
                hit = (cur <= tgt) || (gap <= delta);
                if (hit) nxt = no_dwell ? opp : tgt;
                else     nxt = cur - delta;
            end
        end
    endgenerate

endmodule

// File: rtl/fsweep_ramp.sv
module fsweep_ramp
    import fsweep_pkg::*;
#(
    parameter int FTW_W  = 32,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_en,
    input  logic              no_dwell,
    input  logic              rate_reload,
    input  logic              io_update,
    input  logic              cmd_up,
    input  logic              cmd_dn,
    input  logic [FTW_W-1:0]  act_ftw,
    input  logic [FTW_W-1:0]  lo_ftw,
    input  logic [FTW_W-1:0]  hi_ftw,
    input  logic [FTW_W-1:0]  up_delta,
    input  logic [FTW_W-1:0]  dn_delta,
    input  logic [RATE_W-1:0] up_rate,
    input  logic [RATE_W-1:0] dn_rate,
    output logic [FTW_W-1:0]  ftw
);

    localparam logic [FTW_W-1:0] FTW_RST = '0;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        sweep_mode_e      mode;
    } ramp_s;

    ramp_s s_d, s_q;

    logic              any_cmd;
    logic              upd_reload;
    logic              tmr_start;
    logic              tmr_active;
    logic              step_fire;
    logic [RATE_W-1:0] rate_sel;
    logic [FTW_W-1:0]  up_nxt, dn_nxt;
    logic              up_hit, dn_hit;

    // Countdown start, activity and rate selection
    always_comb begin
        any_cmd    = cmd_up || cmd_dn;
        upd_reload = io_update && rate_reload && (s_q.mode != SM_HOLD);
        tmr_start  = sweep_en && (any_cmd || upd_reload);
        tmr_active = sweep_en && (s_q.mode != SM_HOLD);
        if (cmd_up)                  rate_sel = up_rate;
        else if (cmd_dn)             rate_sel = dn_rate;
        else if (s_q.mode == SM_UP)  rate_sel = up_rate;
        else                         rate_sel = dn_rate;
    end

    fsweep_rate_timer #(.RATE_W(RATE_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .active (tmr_active),
        .rate   (rate_sel),
        .expire (step_fire)
    );

    fsweep_stepper #(.FTW_W(FTW_W), .RISING(1'b1)) i_step_up (
        .cur      (s_q.ftw),
        .delta    (up_delta),
        .tgt      (hi_ftw),
        .opp      (lo_ftw),
        .no_dwell (no_dwell),
        .nxt      (up_nxt),
        .hit      (up_hit)
    );

    fsweep_stepper #(.FTW_W(FTW_W), .RISING(1'b0)) i_step_dn (
        .cur      (s_q.ftw),
        .delta    (dn_delta),
        .tgt      (lo_ftw),
        .opp      (hi_ftw),
        .no_dwell (no_dwell),
        .nxt      (dn_nxt),
        .hit      (dn_hit)
    );

    always_comb begin
        s_d = s_q;
        if (!sweep_en) begin
            s_d.ftw  = act_ftw;
            s_d.mode = SM_HOLD;
        end else if (cmd_up) begin
            s_d.mode = SM_UP;
        end else if (cmd_dn) begin
            s_d.mode = SM_DN;
        end else if (step_fire) begin
            if (s_q.mode == SM_UP) begin
                s_d.ftw = up_nxt;
                if (up_hit) s_d.mode = SM_HOLD;
            end else begin
                s_d.ftw = dn_nxt;
                if (dn_hit) s_d.mode = SM_HOLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ftw  <= FTW_RST;
            s_q.mode <= SM_HOLD;
        end else begin
            s_q <= s_d;
        end
    end

    assign ftw = s_q.ftw;

    AST_DIS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> ftw == $past(act_ftw)); // R1

    AST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !step_fire) |=> $stable(ftw)); // R2

    AST_STEP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        step_fire |-> s_q.mode != SM_HOLD); // R5

    AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && s_q.mode == SM_UP && ftw <= hi_ftw && lo_ftw <= hi_ftw)
        |=> ftw <= $past(hi_ftw)); // R4

    AST_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !no_dwell && s_q.mode == SM_UP && ftw <= hi_ftw)
        |=> ftw >= $past(ftw)); // R2

    AST_DN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !no_dwell && s_q.mode == SM_DN && ftw >= lo_ftw)
        |=> ftw <= $past(ftw)); // R3

endmodule

// File: tb/test_fsweep_ramp.sv
`timescale 1ns/1ps
module test_fsweep_ramp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sweep_en = 1'b0, no_dwell = 1'b0, rate_reload = 1'b0, io_update = 1'b0;
    logic        cmd_up = 1'b0, cmd_dn = 1'b0;
    logic [31:0] act_ftw = '0, lo_ftw = '0, hi_ftw = '0, up_delta = '0, dn_delta = '0;
    logic [15:0] up_rate = '0, dn_rate = '0;
    logic [31:0] ftw;

    int    n_vec = 0;
    int    n_bad = 0;
    string ctx = "R10";

    // bench model state
    logic [31:0] m_ftw = '0;
    logic [15:0] m_cnt = '0;
    int          m_mode = 0; // 0 hold, 1 up, 2 down

    always #2 clk = ~clk;

    fsweep_ramp #(.FTW_W(32), .RATE_W(16)) i_fsweep_ramp (
        .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .no_dwell(no_dwell),
        .rate_reload(rate_reload), .io_update(io_update), .cmd_up(cmd_up),
        .cmd_dn(cmd_dn), .act_ftw(act_ftw), .lo_ftw(lo_ftw), .hi_ftw(hi_ftw),
        .up_delta(up_delta), .dn_delta(dn_delta), .up_rate(up_rate),
        .dn_rate(dn_rate), .ftw(ftw)
    );

    function automatic logic [31:0] step_up(input logic [31:0] c, output bit h);
        h = (c >= hi_ftw) || ((hi_ftw - c) <= up_delta);
        return h ? (no_dwell ? lo_ftw : hi_ftw) : c + up_delta;
    endfunction

    function automatic logic [31:0] step_dn(input logic [31:0] c, output bit h);
        h = (c <= lo_ftw) || ((c - lo_ftw) <= dn_delta);
        return h ? (no_dwell ? hi_ftw : lo_ftw) : c - dn_delta;
    endfunction

    always @(posedge clk) begin
        bit h;
        if (!rst_n) begin
            m_ftw = '0; m_mode = 0; m_cnt = '0;
        end else if (!sweep_en) begin
            m_ftw = act_ftw; m_mode = 0;
        end else if (cmd_up) begin
            m_mode = 1; m_cnt = up_rate;
        end else if (cmd_dn) begin
            m_mode = 2; m_cnt = dn_rate;
        end else if (m_mode != 0) begin
            if (io_update && rate_reload) begin
                m_cnt = (m_mode == 1) ? up_rate : dn_rate;
            end else if (m_cnt == 0) begin
                if (m_mode == 1) begin
                    m_ftw = step_up(m_ftw, h); m_cnt = up_rate;
                end else begin
                    m_ftw = step_dn(m_ftw, h); m_cnt = dn_rate;
                end
                if (h) m_mode = 0;
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end
    end

    // continuous compare against model
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (ftw !== m_ftw) begin
                n_bad++;
                $display("FAIL %s model: ftw=%0d expected %0d at %0t", ctx, ftw, m_ftw, $time);
            end
        end
    end

    task automatic chk(input logic [31:0] exp, input string tag);
        n_vec++;
        if (ftw !== exp) begin
            n_bad++;
            $display("FAIL %s: ftw=%0d expected %0d at %0t", tag, ftw, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        cmd_up = 1'b1; wait_n(1); cmd_up = 1'b0;
    endtask

    task automatic pulse_dn();
        cmd_dn = 1'b1; wait_n(1); cmd_dn = 1'b0;
    endtask

    task automatic park(input logic [31:0] w);
        sweep_en = 1'b0; act_ftw = w; wait_n(1); sweep_en = 1'b1; wait_n(1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        chk(32'd0, "R10");
        rst_n = 1'b1;
        wait_n(1);
        chk(32'd0, "R10");

        // R1: pass-through and ignored commands
        ctx = "R1";
        act_ftw = 32'd77; cmd_up = 1'b1; wait_n(1); cmd_up = 1'b0;
        chk(32'd77, "R1");
        act_ftw = 32'd500; wait_n(4);
        chk(32'd500, "R1");

        // R2, R4, R5: rising ramp with clamp, ordinary hold
        ctx = "R2";
        lo_ftw = 32'd1000; hi_ftw = 32'd1100; up_delta = 32'd30; up_rate = 16'd2;
        park(32'd1000);
        pulse_up();
        chk(32'd1000, "R2");
        wait_n(3); chk(32'd1030, "R2");
        wait_n(3); chk(32'd1060, "R2");
        ctx = "R4";
        wait_n(6); chk(32'd1100, "R4");
        ctx = "R5";
        wait_n(10); chk(32'd1100, "R5");

        // R6: no-dwell falling ramp snaps to the high endpoint
        ctx = "R6";
        no_dwell = 1'b1; dn_delta = 32'd50; dn_rate = 16'd0;
        pulse_dn();
        wait_n(1); chk(32'd1050, "R6");
        wait_n(1); chk(32'd1100, "R6");
        wait_n(5); chk(32'd1100, "R6");
        no_dwell = 1'b0;

        // R8: update strobe reloads countdown
        ctx = "R8";
        up_delta = 32'd10; up_rate = 16'd5; rate_reload = 1'b1;
        park(32'd1000);
        pulse_up();
        wait_n(3);
        io_update = 1'b1; wait_n(1); io_update = 1'b0;
        wait_n(4); chk(32'd1000, "R8");
        wait_n(2); chk(32'd1010, "R8");

        // R7: reversal mid-ramp
        ctx = "R7";
        dn_delta = 32'd4; dn_rate = 16'd1;
        pulse_dn();
        wait_n(2); chk(32'd1006, "R7");

        // R9: simultaneous commands, up wins
        ctx = "R9";
        up_rate = 16'd1;
        cmd_up = 1'b1; cmd_dn = 1'b1; wait_n(1); cmd_up = 1'b0; cmd_dn = 1'b0;
        wait_n(2); chk(32'd1016, "R9");

        // R3: falling ramp to the low endpoint, R8 without reload option
        ctx = "R3";
        rate_reload = 1'b0; dn_delta = 32'd7; dn_rate = 16'd0;
        pulse_dn();
        io_update = 1'b1;
        wait_n(1); chk(32'd1009, "R3");
        wait_n(1); chk(32'd1002, "R8");
        io_update = 1'b0;
        wait_n(1); chk(32'd1000, "R3");
        wait_n(3); chk(32'd1000, "R5");

        // constrained random mixing
        ctx = "R2/R3/R7";
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'd20240611);
        end
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(399) == 0) begin
                lo_ftw   = $urandom_range(1_000_000);
                hi_ftw   = lo_ftw + $urandom_range(4000);
                up_delta = $urandom_range(255, 1);
                dn_delta = $urandom_range(255, 1);
                up_rate  = 16'($urandom_range(15));
                dn_rate  = 16'($urandom_range(15));
            end
            if ($urandom_range(499) == 0) sweep_en = ~sweep_en;
            if ($urandom_range(199) == 0) rate_reload = ~rate_reload;
            if ($urandom_range(299) == 0) no_dwell = ~no_dwell;
            act_ftw   = lo_ftw + $urandom_range(200);
            cmd_up    = ($urandom_range(39) == 0);
            cmd_dn    = ($urandom_range(39) == 0);
            io_update = ($urandom_range(15) == 0);
            wait_n(1);
        end
        cmd_up = 1'b0; cmd_dn = 1'b0; io_update = 1'b0;
        wait_n(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule